// File: doc/BRIEF.md
# PLL Phase Comparator and Charge-Pump Control

This block sits between a programmable N divider and the analog charge pumps of a frequency-synthesis loop. It takes a one-cycle pulse for each edge of the divided local oscillator. It compares that pulse train with a reference tick that it generates itself from the crystal-rate system clock, using one of twelve selectable reference frequencies. The result of the comparison drives four tristate pump controls, each with a separate drive level and output enable. The two main outputs are identical. The auxiliary output has inverted drive polarity. The sub-pump output speeds up locking and behaves according to a 2-bit mode.

A sticky unlock flag records any comparison whose correction pulse lasts longer than a programmable number of clocks. The flag stays set until a clear request arrives. Any of several conditions forces every pump enable low at once and clears the comparison state: reset, clock stop, PLL stop, or the hold input pulled low while hold is enabled.

Top module: `pll_pump_ctrl`

## Requirements
- R1: With select code c in 0..11, the reference tick occurs once every XTAL_KHZ/f system clocks. The frequencies f for codes 0 to 11 are, in order, 1, 3, 3.125, 5, 6.25, 9, 10, 12.5, 25, 30, 50 and 100 kHz. With the default XTAL_KHZ of 4500 these periods are 4500, 1500, 1440, 900, 720, 500, 450, 360, 180, 150, 90 and 45 clocks.
- R2: Select codes 12 to 15 produce no reference tick.
- R3: When a divided-oscillator pulse arrives before the reference tick, both main outputs are enabled with drive 1 from the next clock. They are released (enable 0) one clock after the reference tick arrives. The two main outputs are always equal.
- R4: When the reference tick arrives before the divided pulse, both main outputs are enabled with drive 0 until the clock after the divided pulse.
- R5: A divided pulse and a reference tick in the same clock, starting from the idle state, leave all main enables low.
- R6: The auxiliary output has the same enable as the main outputs and the opposite drive level.
- R7: Sub-pump mode 00 keeps the sub-pump enable low. Mode 11 makes the sub-pump follow the main output in both enable and drive.
- R8: Modes 01 and 10 keep the sub-pump released while the unlock flag is clear. While the flag is set, the sub-pump drives with main polarity on 1 clock in 10 (mode 01, slower rate) or on 2 clocks in 10 (mode 10, faster rate) of an active correction.
- R9: The unlock flag is set after a single correction pulse lasts more than `unlock_limit` clocks. A pulse of exactly `unlock_limit` clocks does not set it.
- R10: Once set, the unlock flag stays set until `unlock_clr` is high on a clock edge, which clears it. Reset also clears it.
- R11: Reset, `clk_stop`, `pll_stop`, or `hold_en` high with `hold_n` low forces all pump enables low in the same cycle and clears the comparison state. Clock stop and PLL stop also halt the reference tick. `hold_n` low has no effect while `hold_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel | input | 4 | Reference frequency select code |
| div_edge | input | 1 | One-cycle pulse per divided-oscillator edge |
| hold_n | input | 1 | Hold input, active low |
| hold_en | input | 1 | Enables the effect of hold_n |
| clk_stop | input | 1 | Clock-stop state |
| pll_stop | input | 1 | PLL-stop state |
| sub_mode | input | 2 | Sub-pump mode |
| unlock_limit | input | CNT_W | Longest correction pulse, in clocks, accepted as locked |
| unlock_clr | input | 1 | Clears the unlock flag |
| ref_tick | output | 1 | Reference tick |
| main1_drv | output | 1 | Main pump 1 drive level |
| main1_oe | output | 1 | Main pump 1 enable |
| main2_drv | output | 1 | Main pump 2 drive level |
| main2_oe | output | 1 | Main pump 2 enable |
| aux_drv | output | 1 | Inverted auxiliary pump drive level |
| aux_oe | output | 1 | Auxiliary pump enable |
| sub_drv | output | 1 | Sub-pump drive level |
| sub_oe | output | 1 | Sub-pump enable |
| unlock | output | 1 | Sticky unlock flag |

## Verification
A divided pulse or reference tick sampled on a clock edge changes the pump enables just after that same edge. The bench therefore drives stimulus at a falling edge and reads the pumps at the next falling edge. The unlock flag rises after the edge that samples the pulse's (limit+1)-th active clock, so it is read at the falling edge that follows the end of the pulse. The gating inputs act combinationally and are checked one nanosecond after they change. Reference periods are measured by counting falling edges between two ticks, after one full period has passed since the select change.

// File: rtl/pllpc_pkg.sv
package pllpc_pkg;

    typedef enum logic [1:0] {
        SUB_OFF       = 2'b00,
        SUB_UNLK_SLOW = 2'b01,
        SUB_UNLK_FAST = 2'b10,
        SUB_FULL      = 2'b11
    } sub_mode_e;

    typedef struct packed {
        logic drv;
        logic oe;
    } pump_t;

    // Divide ratio from the crystal rate to the selected reference.
    // Frequencies are held in eighths of a kHz so that every entry is exact.
    // Returns 0 for an unused code.
    function automatic int unsigned ref_ratio(input logic [3:0] code,
                                              input int unsigned xtal_khz);
        int unsigned k8;
        k8 = xtal_khz * 8;
        case (code)
            4'd0:    return k8 / 8;
            4'd1:    return k8 / 24;
            4'd2:    return k8 / 25;
            4'd3:    return k8 / 40;
            4'd4:    return k8 / 50;
            4'd5:    return k8 / 72;
            4'd6:    return k8 / 80;
            4'd7:    return k8 / 100;
            4'd8:    return k8 / 200;
            4'd9:    return k8 / 240;
            4'd10:   return k8 / 400;
            4'd11:   return k8 / 800;
            default: return 0;
        endcase
    endfunction

    function automatic pump_t pump_invert(input pump_t p);
        pump_t q;
        q.drv = ~p.drv;
        q.oe  = p.oe;
        return q;
    endfunction

endpackage

// File: rtl/pllpc_ref_div.sv
module pllpc_ref_div
    import pllpc_pkg::*;
#(
    parameter int unsigned XTAL_KHZ = 4500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt,
    input  logic [3:0] sel,
    output logic       tick
);
    localparam int CW = $clog2(XTAL_KHZ + 1);

    logic [CW-1:0] cnt_q;
    int unsigned   ratio;
    logic          valid;
    logic          last;

    always_comb begin
        ratio = ref_ratio(sel, XTAL_KHZ);
        valid = (ratio != 0);
        last  = valid && ((32'(cnt_q) + 32'd1) >= ratio);
        tick  = last && !halt;
    end

    always_ff @(posedge clk) begin
        if (rst || halt || !valid) begin
            cnt_q <= '0;
        end else if (last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pllpc_pfd.sv
module pllpc_pfd
    import pllpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  gate,
    input  logic  div_edge,
    input  logic  ref_tick,
    output pump_t pump
);
    logic fast_q, slow_q;
    logic fast_d, slow_d;

    always_comb begin
        fast_d = fast_q | div_edge;
        slow_d = slow_q | ref_tick;
        if (fast_d && slow_d) begin
            fast_d = 1'b0;
            slow_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || gate) begin
            fast_q <= 1'b0;
            slow_q <= 1'b0;
        end else begin
            fast_q <= fast_d;
            slow_q <= slow_d;
        end
    end

    always_comb begin
        pump.drv = fast_q;
        pump.oe  = (fast_q ^ slow_q) && !gate;
    end
endmodule

// File: rtl/pllpc_unlock.sv
module pllpc_unlock #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr,
    output logic             unlock
);
    logic [CNT_W-1:0] width_q;
    logic             over;

    assign over = active && (width_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            width_q <= '0;
        end else if (width_q != {CNT_W{1'b1}}) begin
            width_q <= width_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock <= 1'b0;
        end else if (over) begin
            unlock <= 1'b1;
        end else if (clr) begin
            unlock <= 1'b0;
        end
    end
endmodule

// File: rtl/pllpc_sub.sv
module pllpc_sub
    import pllpc_pkg::*;
#(
    parameter int unsigned CHOP_FAST = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       unlock,
    input  pump_t      main_p,
    output pump_t      sub_p
);
    localparam int unsigned CHOP_SLOW = 2 * CHOP_FAST;
    localparam int          CHW       = $clog2(CHOP_SLOW);

    logic [CHW-1:0] chop_q;
    logic           strobe_slow, strobe_fast;
    logic           en;
    sub_mode_e      mode_e;

    assign mode_e = sub_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst || (chop_q == CHW'(CHOP_SLOW - 1))) begin
            chop_q <= '0;
        end else begin
            chop_q <= chop_q + 1'b1;
        end
    end

    assign strobe_slow = (chop_q == '0);
    assign strobe_fast = (chop_q == '0) || (chop_q == CHW'(CHOP_FAST));

    always_comb begin
        case (mode_e)
            SUB_OFF:       en = 1'b0;
            SUB_UNLK_SLOW: en = unlock && strobe_slow;
            SUB_UNLK_FAST: en = unlock && strobe_fast;
            SUB_FULL:      en = 1'b1;
            default:       en = 1'b0;
        endcase
        sub_p.drv = main_p.drv;
        sub_p.oe  = main_p.oe && en;
    end
endmodule

// File: rtl/pll_pump_ctrl.sv
module pll_pump_ctrl
    import pllpc_pkg::*;
#(
    parameter int unsigned XTAL_KHZ = 4500,
    parameter int          CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ref_sel,
    input  logic             div_edge,
    input  logic             hold_n,
    input  logic             hold_en,
    input  logic             clk_stop,
    input  logic             pll_stop,
    input  logic [1:0]       sub_mode,
    input  logic [CNT_W-1:0] unlock_limit,
    input  logic             unlock_clr,
    output logic             ref_tick,
    output logic             main1_drv,
    output logic             main1_oe,
    output logic             main2_drv,
    output logic             main2_oe,
    output logic             aux_drv,
    output logic             aux_oe,
    output logic             sub_drv,
    output logic             sub_oe,
    output logic             unlock
);
    localparam int unsigned CHOP_FAST = XTAL_KHZ / 900;

    logic  halt;
    logic  gate;
    pump_t main_p, aux_p, sub_p;

    assign halt = clk_stop || pll_stop;
    assign gate = rst || halt || (hold_en && !hold_n);

    pllpc_ref_div #(.XTAL_KHZ(XTAL_KHZ)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .halt (halt),
        .sel  (ref_sel),
        .tick (ref_tick)
    );

    pllpc_pfd u_pfd (
        .clk      (clk),
        .rst      (rst),
        .gate     (gate),
        .div_edge (div_edge),
        .ref_tick (ref_tick),
        .pump     (main_p)
    );

    pllpc_unlock #(.CNT_W(CNT_W)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .active (main_p.oe),
        .limit  (unlock_limit),
        .clr    (unlock_clr),
        .unlock (unlock)
    );

    pllpc_sub #(.CHOP_FAST(CHOP_FAST)) u_sub (
        .clk    (clk),
        .rst    (rst),
        .mode   (sub_mode),
        .unlock (unlock),
        .main_p (main_p),
        .sub_p  (sub_p)
    );

    assign aux_p = pump_invert(main_p);

    assign main1_drv = main_p.drv;
    assign main1_oe  = main_p.oe;
    assign main2_drv = main_p.drv;
    assign main2_oe  = main_p.oe;
    assign aux_drv   = aux_p.drv;
    assign aux_oe    = aux_p.oe;
    assign sub_drv   = sub_p.drv;
    assign sub_oe    = sub_p.oe;
endmodule

// File: rtl/pll_pump_ctrl_chk.sv
module pll_pump_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       clk_stop,
    input logic       pll_stop,
    input logic       hold_en,
    input logic       hold_n,
    input logic [3:0] ref_sel,
    input logic       ref_tick,
    input logic       div_edge,
    input logic [1:0] sub_mode,
    input logic       unlock,
    input logic       unlock_clr,
    input logic       main1_drv,
    input logic       main1_oe,
    input logic       main2_drv,
    input logic       main2_oe,
    input logic       aux_drv,
    input logic       aux_oe,
    input logic       sub_drv,
    input logic       sub_oe
);
    p_no_ref_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_sel >= 4'd12) |-> !ref_tick);

    p_main_twins_r3: assert property (@(posedge clk) disable iff (rst)
        (main1_oe == main2_oe) && (!main1_oe || (main1_drv == main2_drv)));

    p_coincide_r5: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && div_edge && !main1_oe) |=> !main1_oe);

    p_aux_inverse_r6: assert property (@(posedge clk) disable iff (rst)
        (aux_oe == main1_oe) && (!aux_oe || (aux_drv != main1_drv)));

    p_sub_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (sub_mode == 2'b00) |-> !sub_oe);

    p_sub_follow_r7: assert property (@(posedge clk) disable iff (rst)
        sub_oe |-> (main1_oe && (sub_drv == main1_drv)));

    p_sub_locked_r8: assert property (@(posedge clk) disable iff (rst)
        ((sub_mode == 2'b01 || sub_mode == 2'b10) && !unlock) |-> !sub_oe);

    p_unlock_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock) |-> $past(main1_oe));

    p_unlock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (unlock && !unlock_clr) |=> unlock);

    p_gate_hiz_r11: assert property (@(posedge clk) disable iff (rst)
        (clk_stop || pll_stop || (hold_en && !hold_n))
            |-> !(main1_oe || main2_oe || aux_oe || sub_oe));
endmodule

bind pll_pump_ctrl pll_pump_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_stop   (clk_stop),
    .pll_stop   (pll_stop),
    .hold_en    (hold_en),
    .hold_n     (hold_n),
    .ref_sel    (ref_sel),
    .ref_tick   (ref_tick),
    .div_edge   (div_edge),
    .sub_mode   (sub_mode),
    .unlock     (unlock),
    .unlock_clr (unlock_clr),
    .main1_drv  (main1_drv),
    .main1_oe   (main1_oe),
    .main2_drv  (main2_drv),
    .main2_oe   (main2_oe),
    .aux_drv    (aux_drv),
    .aux_oe     (aux_oe),
    .sub_drv    (sub_drv),
    .sub_oe     (sub_oe)
);

// File: tb/pll_pump_ctrl_test.sv
`timescale 1ns/1ps
module pll_pump_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ref_sel = 4'd11;
    logic       div_edge = 1'b0;
    logic       hold_n = 1'b1;
    logic       hold_en = 1'b0;
    logic       clk_stop = 1'b0;
    logic       pll_stop = 1'b0;
    logic [1:0] sub_mode = 2'b11;
    logic [7:0] unlock_limit = 8'd255;
    logic       unlock_clr = 1'b0;
    logic ref_tick, main1_drv, main1_oe, main2_drv, main2_oe;
    logic aux_drv, aux_oe, sub_drv, sub_oe, unlock;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pll_pump_ctrl uut (
        .clk(clk), .rst(rst), .ref_sel(ref_sel), .div_edge(div_edge),
        .hold_n(hold_n), .hold_en(hold_en), .clk_stop(clk_stop),
        .pll_stop(pll_stop), .sub_mode(sub_mode), .unlock_limit(unlock_limit),
        .unlock_clr(unlock_clr), .ref_tick(ref_tick),
        .main1_drv(main1_drv), .main1_oe(main1_oe),
        .main2_drv(main2_drv), .main2_oe(main2_oe),
        .aux_drv(aux_drv), .aux_oe(aux_oe),
        .sub_drv(sub_drv), .sub_oe(sub_oe), .unlock(unlock)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int any_oe();
        return int'(main1_oe) + int'(main2_oe) + int'(aux_oe) + int'(sub_oe);
    endfunction

    task automatic wait_tick();
        do @(negedge clk); while (!ref_tick);
    endtask

    // Divided pulse coincident with a tick: leaves the comparator idle.
    task automatic sync_idle();
        wait_tick();
        div_edge = 1'b1;
        @(negedge clk);
        div_edge = 1'b0;
    endtask

    // Reference first, divided pulse d clocks later; counts per-cycle outputs.
    task automatic slow_pulse(input int d, output int n_main, output int n_aux, output int n_sub);
        n_main = 0; n_aux = 0; n_sub = 0;
        wait_tick();
        for (int i = 1; i <= d; i++) begin
            @(negedge clk);
            if (main1_oe && !main1_drv && main2_oe && !main2_drv) n_main++;
            if (aux_oe && aux_drv) n_aux++;
            if (sub_oe && !sub_drv) n_sub++;
            if (i == d) div_edge = 1'b1;
        end
        @(negedge clk);
        div_edge = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(any_oe() == 0, "R11 enables in reset", any_oe(), 0);
        check(!ref_tick, "R11 no tick in reset", ref_tick, 0);
        check(!unlock, "R10 unlock clear after reset", unlock, 0);
        rst = 1'b0;
    endtask

    task automatic t_period(input logic [3:0] code, input int exp);
        int n;
        ref_sel = code;
        wait_tick();
        wait_tick();
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_tick && n < 6000);
        check(n == exp, "R1 reference period", n, exp);
    endtask

    task automatic t_invalid();
        int seen = 0;
        ref_sel = 4'd13;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ref_tick) seen++;
        end
        check(seen == 0, "R2 no tick for code 13", seen, 0);
        ref_sel = 4'd11;
    endtask

    task automatic t_fast();
        sub_mode = 2'b11;
        sync_idle();
        div_edge = 1'b1;
        @(negedge clk);
        div_edge = 1'b0;
        check(main1_oe && main1_drv && main2_oe && main2_drv, "R3 main drive high",
              {main1_oe, main1_drv, main2_oe, main2_drv}, 4'b1111);
        check(aux_oe && !aux_drv, "R6 aux drive low", {aux_oe, aux_drv}, 2'b10);
        check(sub_oe && sub_drv, "R7 sub follows in mode 11", {sub_oe, sub_drv}, 2'b11);
        wait_tick();
        check(main1_oe, "R3 held until tick", main1_oe, 1);
        @(negedge clk);
        check(any_oe() == 0, "R3 released after tick", any_oe(), 0);
    endtask

    task automatic t_slow();
        int nm, na, ns;
        sub_mode = 2'b11;
        sync_idle();
        slow_pulse(8, nm, na, ns);
        check(nm == 8, "R4 main drive low cycles", nm, 8);
        check(na == 8, "R6 aux drive high cycles", na, 8);
        check(ns == 8, "R7 sub low in mode 11", ns, 8);
        check(any_oe() == 0, "R4 released after divided pulse", any_oe(), 0);
    endtask

    task automatic t_coincide();
        for (int k = 0; k < 3; k++) begin
            sync_idle();
            check(any_oe() == 0, "R5 coincident edges", any_oe(), 0);
        end
    endtask

    task automatic t_sub_and_lock();
        int nm, na, ns;
        unlock_limit = 8'd255;
        unlock_clr = 1'b1; @(negedge clk); unlock_clr = 1'b0;
        sync_idle();
        sub_mode = 2'b00; slow_pulse(20, nm, na, ns);
        check(ns == 0, "R7 mode 00 silent", ns, 0);
        sub_mode = 2'b01; slow_pulse(20, nm, na, ns);
        check(ns == 0, "R8 mode 01 locked silent", ns, 0);
        sub_mode = 2'b10; slow_pulse(20, nm, na, ns);
        check(ns == 0, "R8 mode 10 locked silent", ns, 0);
        unlock_limit = 8'd10;
        sub_mode = 2'b00; slow_pulse(10, nm, na, ns);
        check(!unlock, "R9 pulse equal to limit", unlock, 0);
        slow_pulse(11, nm, na, ns);
        check(unlock, "R9 pulse over limit", unlock, 1);
        unlock_limit = 8'd255;
        sub_mode = 2'b01; slow_pulse(20, nm, na, ns);
        check(ns == 2, "R8 mode 01 unlocked rate", ns, 2);
        sub_mode = 2'b10; slow_pulse(20, nm, na, ns);
        check(ns == 4, "R8 mode 10 unlocked rate", ns, 4);
        sub_mode = 2'b11; slow_pulse(20, nm, na, ns);
        check(ns == 20, "R7 mode 11 full", ns, 20);
        check(unlock, "R10 flag sticky", unlock, 1);
        unlock_clr = 1'b1; @(negedge clk); unlock_clr = 1'b0;
        check(!unlock, "R10 cleared by request", unlock, 0);
    endtask

    task automatic t_gate();
        int seen = 0;
        sub_mode = 2'b11;
        sync_idle();
        div_edge = 1'b1; @(negedge clk); div_edge = 1'b0;
        pll_stop = 1'b1; #1;
        check(any_oe() == 0, "R11 pll stop forces release", any_oe(), 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (ref_tick) seen++;
        end
        check(seen == 0, "R11 pll stop halts tick", seen, 0);
        pll_stop = 1'b0; @(negedge clk);
        check(any_oe() == 0, "R11 state cleared by stop", any_oe(), 0);
        sync_idle();
        div_edge = 1'b1; @(negedge clk); div_edge = 1'b0;
        clk_stop = 1'b1; #1;
        check(any_oe() == 0, "R11 clock stop forces release", any_oe(), 0);
        clk_stop = 1'b0;
        sync_idle();
        hold_en = 1'b1; hold_n = 1'b0;
        div_edge = 1'b1; @(negedge clk); div_edge = 1'b0;
        check(any_oe() == 0, "R11 hold blocks pumps", any_oe(), 0);
        hold_n = 1'b1; @(negedge clk);
        check(any_oe() == 0, "R11 divided pulse ignored in hold", any_oe(), 0);
        hold_en = 1'b0; hold_n = 1'b0;
        sync_idle();
        div_edge = 1'b1; @(negedge clk); div_edge = 1'b0;
        check(main1_oe && main1_drv, "R11 hold_n without enable", {main1_oe, main1_drv}, 2'b11);
        hold_n = 1'b1;
        sync_idle();
    endtask

    initial begin
        t_reset();
        t_period(4'd11, 45);
        t_period(4'd8, 180);
        t_period(4'd2, 1440);
        t_period(4'd0, 4500);
        ref_sel = 4'd11;
        t_invalid();
        t_fast();
        t_slow();
        t_coincide();
        t_sub_and_lock();
        t_gate();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (R1..R11 run): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule